// File: doc/BRIEF.md
# External Data Space Decoder with Sampling Port

This block sits between an 8-bit microcontroller's external data bus and the memories behind it. A 16-bit CPU address is steered to one of three regions: a 4 KB working RAM that the CPU shares with a measurement engine, a 256-byte volatile configuration RAM, and an 8-byte battery-backed bank that occupies a hole inside the configuration window. Addresses that match none of these have no storage behind them.

A second, narrow write port lets an ADC front end deposit samples into the lowest 64 bytes of the shared RAM. That port is live only while the 4-bit divider setting is nonzero; with the setting at zero, every sample write is discarded. If the CPU and the ADC write into that 64-byte window in the same cycle, the sample is kept and the CPU write is lost. Reads take one cycle from address to data.

Reset clears the shared RAM and the configuration RAM. The battery bank is untouched by reset and is zeroed only by a dedicated power-on-clear input.

Top module: `xdata_decoder`

## Requirements
- R1: A CPU read presented with `cpu_rd` high shows its data on `cpu_rdata` one clock edge later. The data is then held while `cpu_rd` stays low. Shared RAM responds at 0x0000 to 0x0FFF.
- R2: The configuration RAM responds at 0x2000 to 0x20BF and at 0x20C8 to 0x20FF. Each byte is stored at its own offset.
- R3: Addresses 0x20C0 to 0x20C7 reach an 8-byte bank of their own. A write there leaves the configuration RAM unchanged, and every other region is likewise left unchanged.
- R4: A read from any other address (for example 0x1000, 0x1FFF, 0x2100 or 0xFFFF) returns 0x00. A write to such an address changes no stored byte.
- R5: While `mux_div` is nonzero, an `adc_wr` pulse stores `adc_wdata` at shared address `adc_addr` (range 0x00 to 0x3F).
- R6: While `mux_div` is 0, `adc_wr` has no effect on any stored byte.
- R7: When a committed ADC write and a CPU write to shared addresses 0x0000 to 0x003F occur in the same cycle, the ADC byte is stored and the CPU byte is dropped. This holds even if the two target different bytes.
- R8: A CPU write to a shared address at or above 0x0040 completes even when an ADC write happens in the same cycle.
- R9: After `rst_n` is asserted, `cpu_rdata` reads 0x00, and every shared and configuration byte reads 0x00.
- R10: `rst_n` leaves the battery bank unchanged. A cycle with `por_clr` high zeroes all 8 bytes of that bank.
- R11: A read and a write to the same address in the same cycle return the byte held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears volatile storage and read data |
| por_clr | input | 1 | Power-on clear of the battery bank |
| cpu_addr | input | 16 | CPU external data address |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data, one cycle after the strobe |
| mux_div | input | 4 | Divider setting; zero disables the sample port |
| adc_wr | input | 1 | Sample write strobe |
| adc_addr | input | 6 | Sample byte index within the low window |
| adc_wdata | input | 8 | Sample data |

## Verification
A decoder that places a region at the wrong place shows up on the first read-back of that byte, one cycle after the read strobe. A mis-decoded write also corrupts a byte in another region, so reading a neighbouring region exposes it. Errors in the ADC gating or arbitration stay hidden until a later CPU read of the low window, which is why every sample test reads back both the sample byte and the CPU byte it competed with. A battery bank that reset wrongly clears shows only after a reset, in the first read of 0x20C0 to 0x20C7.

// File: rtl/xdm_pkg.sv
package xdm_pkg;
   typedef enum logic [1:0] {
      RG_NONE = 2'd0,
      RG_SHR  = 2'd1,
      RG_CFG  = 2'd2,
      RG_BAT  = 2'd3
   } xdm_region_e;
endpackage

// File: rtl/xdm_addr_decode.sv
module xdm_addr_decode
   import xdm_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int SHR_BASE  = 0,
   parameter int SHR_BYTES = 4096,
   parameter int CFG_BASE  = 'h2000,
   parameter int CFG_BYTES = 256,
   parameter int BAT_OFS   = 'hC0,
   parameter int BAT_BYTES = 8,
   localparam int SHR_AW   = $clog2(SHR_BYTES),
   localparam int CFG_AW   = $clog2(CFG_BYTES),
   localparam int BAT_AW   = $clog2(BAT_BYTES)
) (
   input  logic [ADDR_W-1:0] addr,
   output xdm_region_e       region,
   output logic [SHR_AW-1:0] shr_idx,
   output logic [CFG_AW-1:0] cfg_idx,
   output logic [BAT_AW-1:0] bat_idx
);
   localparam logic [ADDR_W:0] SHR_LO = (ADDR_W+1)'(SHR_BASE);
   localparam logic [ADDR_W:0] SHR_HI = (ADDR_W+1)'(SHR_BASE + SHR_BYTES);
   localparam logic [ADDR_W:0] CFG_LO = (ADDR_W+1)'(CFG_BASE);
   localparam logic [ADDR_W:0] CFG_HI = (ADDR_W+1)'(CFG_BASE + CFG_BYTES);
   localparam logic [CFG_AW:0] BAT_LO = (CFG_AW+1)'(BAT_OFS);
   localparam logic [CFG_AW:0] BAT_HI = (CFG_AW+1)'(BAT_OFS + BAT_BYTES);

   logic [ADDR_W:0] a_ext;
   logic [ADDR_W:0] shr_rel;
   logic [ADDR_W:0] cfg_rel;
   logic [CFG_AW:0] cfg_ofs;
   logic [CFG_AW:0] bat_rel;
   logic            in_shr;
   logic            in_cfg;
   logic            in_bat;

   always_comb begin
      a_ext   = {1'b0, addr};
      shr_rel = a_ext - SHR_LO;
      cfg_rel = a_ext - CFG_LO;
      cfg_ofs = {1'b0, cfg_rel[CFG_AW-1:0]};
      bat_rel = cfg_ofs - BAT_LO;
      in_shr  = (a_ext >= SHR_LO) && (a_ext < SHR_HI);
      in_cfg  = (a_ext >= CFG_LO) && (a_ext < CFG_HI);
      in_bat  = in_cfg && (cfg_ofs >= BAT_LO) && (cfg_ofs < BAT_HI);
      shr_idx = shr_rel[SHR_AW-1:0];
      cfg_idx = cfg_rel[CFG_AW-1:0];
      bat_idx = bat_rel[BAT_AW-1:0];
      if (in_bat)      region = RG_BAT;
      else if (in_cfg) region = RG_CFG;
      else if (in_shr) region = RG_SHR;
      else             region = RG_NONE;
   end
endmodule

// File: rtl/xdm_shared_ram.sv
module xdm_shared_ram #(
   parameter int DATA_W    = 8,
   parameter int DEPTH     = 4096,
   parameter int WIN_BYTES = 64,
   parameter bit ADC_WINS  = 1'b1,
   localparam int AW       = $clog2(DEPTH),
   localparam int WAW      = $clog2(WIN_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_we,
   input  logic [AW-1:0]     cpu_idx,
   input  logic [DATA_W-1:0] cpu_wd,
   input  logic              adc_we,
   input  logic [WAW-1:0]    adc_idx,
   input  logic [DATA_W-1:0] adc_wd,
   input  logic              rd_en,
   input  logic [AW-1:0]     rd_idx,
   output logic [DATA_W-1:0] rd_q,
   output logic              cpu_commit,
   output logic              adc_commit
);
   logic [DATA_W-1:0] mem [DEPTH];
   logic              cpu_in_win;
   logic [AW-1:0]     adc_full;

   assign adc_full = AW'(adc_idx);

   generate
      if (WIN_BYTES == DEPTH) begin : g_win_all
         assign cpu_in_win = 1'b1;
      end else begin : g_win_low
         localparam logic [AW-1:0] WIN_LIM = AW'(WIN_BYTES);
         assign cpu_in_win = cpu_idx < WIN_LIM;
      end

      if (ADC_WINS) begin : g_adc_prio
         assign adc_commit = adc_we;
         assign cpu_commit = cpu_we && !(adc_we && cpu_in_win);
      end else begin : g_cpu_prio
         assign cpu_commit = cpu_we;
         assign adc_commit = adc_we && !(cpu_we && cpu_in_win);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
         rd_q <= '0;
      end else begin
         if (rd_en)      rd_q <= mem[rd_idx];
         if (cpu_commit) mem[cpu_idx] <= cpu_wd;
         if (adc_commit) mem[adc_full] <= adc_wd;
      end
   end
endmodule

// File: rtl/xdm_cfg_bank.sv
module xdm_cfg_bank #(
   parameter int DATA_W    = 8,
   parameter int CFG_BYTES = 256,
   parameter int BAT_BYTES = 8,
   localparam int CAW      = $clog2(CFG_BYTES),
   localparam int BAW      = $clog2(BAT_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              por_clr,
   input  logic              cfg_we,
   input  logic [CAW-1:0]    cfg_idx,
   input  logic              bat_we,
   input  logic [BAW-1:0]    bat_idx,
   input  logic [DATA_W-1:0] wd,
   input  logic              rd_cfg,
   input  logic              rd_bat,
   output logic [DATA_W-1:0] rd_q
);
   logic [DATA_W-1:0] cfg_mem [CFG_BYTES];
   logic [DATA_W-1:0] bat_mem [BAT_BYTES];

   // Volatile bank: cleared by reset.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < CFG_BYTES; i++) cfg_mem[i] <= '0;
         rd_q <= '0;
      end else begin
         if (rd_bat)      rd_q <= bat_mem[bat_idx];
         else if (rd_cfg) rd_q <= cfg_mem[cfg_idx];
         if (cfg_we)      cfg_mem[cfg_idx] <= wd;
      end
   end

   // Retained bank: only the power-on clear zeroes it.
   always_ff @(posedge clk) begin
      if (por_clr) begin
         for (int i = 0; i < BAT_BYTES; i++) bat_mem[i] <= '0;
      end else if (bat_we) begin
         bat_mem[bat_idx] <= wd;
      end
   end
endmodule

// File: rtl/xdata_decoder.sv
module xdata_decoder
   import xdm_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 8,
   parameter int DIV_W     = 4,
   parameter int SHR_BASE  = 0,
   parameter int SHR_BYTES = 4096,
   parameter int WIN_BYTES = 64,
   parameter int CFG_BASE  = 'h2000,
   parameter int CFG_BYTES = 256,
   parameter int BAT_OFS   = 'hC0,
   parameter int BAT_BYTES = 8,
   parameter bit ADC_WINS  = 1'b1,
   localparam int WAW      = $clog2(WIN_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              por_clr,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic              cpu_rd,
   input  logic              cpu_wr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic [DATA_W-1:0] cpu_rdata,
   input  logic [DIV_W-1:0]  mux_div,
   input  logic              adc_wr,
   input  logic [WAW-1:0]    adc_addr,
   input  logic [DATA_W-1:0] adc_wdata
);
   localparam int SHR_AW = $clog2(SHR_BYTES);
   localparam int CFG_AW = $clog2(CFG_BYTES);
   localparam int BAT_AW = $clog2(BAT_BYTES);

   // Elaboration-time parameter checks
   generate
      if ((SHR_BYTES & (SHR_BYTES - 1)) != 0) begin : g_chk_shr
         $error("shared RAM depth must be a power of two");
      end
      if ((WIN_BYTES & (WIN_BYTES - 1)) != 0 || WIN_BYTES > SHR_BYTES) begin : g_chk_win
         $error("sample window must be a power of two within the shared RAM");
      end
      if (BAT_OFS + BAT_BYTES > CFG_BYTES || BAT_BYTES < 2) begin : g_chk_bat
         $error("battery bank must lie inside the configuration window");
      end
      if (SHR_BASE + SHR_BYTES > CFG_BASE || CFG_BASE + CFG_BYTES > (1 << ADDR_W)) begin : g_chk_map
         $error("regions overlap or exceed the address space");
      end
   endgenerate

   xdm_region_e       hit_rg;
   xdm_region_e       rg_q;
   logic [SHR_AW-1:0] shr_idx;
   logic [CFG_AW-1:0] cfg_idx;
   logic [BAT_AW-1:0] bat_idx;
   logic              adc_go;
   logic              shr_cpu_we;
   logic              shr_cpu_commit;
   logic              shr_adc_commit;
   logic              cfg_we;
   logic              bat_we;
   logic [DATA_W-1:0] shr_q;
   logic [DATA_W-1:0] cfg_q;

   xdm_addr_decode #(
      .ADDR_W(ADDR_W), .SHR_BASE(SHR_BASE), .SHR_BYTES(SHR_BYTES),
      .CFG_BASE(CFG_BASE), .CFG_BYTES(CFG_BYTES),
      .BAT_OFS(BAT_OFS), .BAT_BYTES(BAT_BYTES)
   ) u_dec (
      .addr(cpu_addr), .region(hit_rg),
      .shr_idx(shr_idx), .cfg_idx(cfg_idx), .bat_idx(bat_idx)
   );

   assign adc_go     = adc_wr && (|mux_div);
   assign shr_cpu_we = cpu_wr && (hit_rg == RG_SHR);
   assign cfg_we     = cpu_wr && (hit_rg == RG_CFG);
   assign bat_we     = cpu_wr && (hit_rg == RG_BAT);

   xdm_shared_ram #(
      .DATA_W(DATA_W), .DEPTH(SHR_BYTES), .WIN_BYTES(WIN_BYTES), .ADC_WINS(ADC_WINS)
   ) u_shr (
      .clk(clk), .rst_n(rst_n),
      .cpu_we(shr_cpu_we), .cpu_idx(shr_idx), .cpu_wd(cpu_wdata),
      .adc_we(adc_go), .adc_idx(adc_addr), .adc_wd(adc_wdata),
      .rd_en(cpu_rd && (hit_rg == RG_SHR)), .rd_idx(shr_idx), .rd_q(shr_q),
      .cpu_commit(shr_cpu_commit), .adc_commit(shr_adc_commit)
   );

   xdm_cfg_bank #(
      .DATA_W(DATA_W), .CFG_BYTES(CFG_BYTES), .BAT_BYTES(BAT_BYTES)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .por_clr(por_clr),
      .cfg_we(cfg_we), .cfg_idx(cfg_idx),
      .bat_we(bat_we), .bat_idx(bat_idx), .wd(cpu_wdata),
      .rd_cfg(cpu_rd && (hit_rg == RG_CFG)),
      .rd_bat(cpu_rd && (hit_rg == RG_BAT)),
      .rd_q(cfg_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rg_q <= RG_NONE;
      else if (cpu_rd) rg_q <= hit_rg;
   end

   always_comb begin
      unique case (rg_q)
         RG_SHR:         cpu_rdata = shr_q;
         RG_CFG, RG_BAT: cpu_rdata = cfg_q;
         default:        cpu_rdata = '0;
      endcase
   end
endmodule

// File: rtl/xdm_checker.sv
module xdm_checker
   import xdm_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 8,
   parameter int DIV_W     = 4,
   parameter int WIN_BYTES = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_rd,
   input logic [ADDR_W-1:0] cpu_addr,
   input logic [DATA_W-1:0] cpu_rdata,
   input logic [DIV_W-1:0]  mux_div,
   input xdm_region_e       hit_rg,
   input logic              shr_cpu_commit,
   input logic              shr_adc_commit,
   input logic              cfg_we,
   input logic              bat_we
);
   localparam logic [ADDR_W-1:0] WIN_LIM = ADDR_W'(WIN_BYTES);

   AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_rd |=> $stable(cpu_rdata));                                        // R1
   AST_UNPOP_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_rd && hit_rg == RG_NONE) |=> (cpu_rdata == '0));                   // R4
   AST_UNPOP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_rg == RG_NONE) |-> !(shr_cpu_commit || cfg_we || bat_we));         // R4
   AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({shr_cpu_commit, cfg_we, bat_we}));                            // R3
   AST_WIN_ARB: assert property (@(posedge clk) disable iff (!rst_n)
      (shr_adc_commit && shr_cpu_commit) |-> (cpu_addr >= WIN_LIM));          // R7
   AST_ADC_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      shr_adc_commit |-> (mux_div != '0));                                    // R6
endmodule

bind xdata_decoder xdm_checker #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIV_W(DIV_W), .WIN_BYTES(WIN_BYTES)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cpu_rd(cpu_rd), .cpu_addr(cpu_addr),
   .cpu_rdata(cpu_rdata), .mux_div(mux_div), .hit_rg(hit_rg),
   .shr_cpu_commit(shr_cpu_commit), .shr_adc_commit(shr_adc_commit),
   .cfg_we(cfg_we), .bat_we(bat_we)
);

// File: tb/test_xdata_decoder.sv
`timescale 1ns/100ps
module test_xdata_decoder;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        por_clr = 1'b1;
   logic [15:0] cpu_addr = '0;
   logic        cpu_rd = 1'b0;
   logic        cpu_wr = 1'b0;
   logic [7:0]  cpu_wdata = '0;
   logic [7:0]  cpu_rdata;
   logic [3:0]  mux_div = '0;
   logic        adc_wr = 1'b0;
   logic [5:0]  adc_addr = '0;
   logic [7:0]  adc_wdata = '0;

   int  n_checks = 0;
   int  n_errors = 0;
   bit  done = 1'b0;

   always #2.5 clk = ~clk;

   xdata_decoder i_xdata_decoder (
      .clk(clk), .rst_n(rst_n), .por_clr(por_clr),
      .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
      .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
      .mux_div(mux_div), .adc_wr(adc_wr), .adc_addr(adc_addr), .adc_wdata(adc_wdata)
   );

   // Vector: {kind(1)=1 read-check / 0 write, req(4), addr(16), data(8)}
   localparam int NV = 25;
   localparam logic [28:0] VEC [NV] = '{
      {1'b0, 4'd1, 16'h0000, 8'h11},   // R1
      {1'b0, 4'd1, 16'h0FFF, 8'h22},   // R1
      {1'b0, 4'd2, 16'h2000, 8'h33},   // R2
      {1'b0, 4'd2, 16'h20BF, 8'h44},   // R2
      {1'b0, 4'd2, 16'h20C8, 8'h55},   // R2
      {1'b0, 4'd2, 16'h20FF, 8'h66},   // R2
      {1'b0, 4'd3, 16'h20C0, 8'h77},   // R3
      {1'b0, 4'd3, 16'h20C7, 8'h88},   // R3
      {1'b0, 4'd4, 16'h1000, 8'h99},   // R4
      {1'b0, 4'd4, 16'h2100, 8'hAA},   // R4
      {1'b0, 4'd4, 16'hFFFF, 8'hBB},   // R4
      {1'b1, 4'd1, 16'h0000, 8'h11},   // R1
      {1'b1, 4'd1, 16'h0FFF, 8'h22},   // R1
      {1'b1, 4'd2, 16'h2000, 8'h33},   // R2
      {1'b1, 4'd2, 16'h20BF, 8'h44},   // R2
      {1'b1, 4'd2, 16'h20C8, 8'h55},   // R2
      {1'b1, 4'd2, 16'h20FF, 8'h66},   // R2
      {1'b1, 4'd3, 16'h20C0, 8'h77},   // R3
      {1'b1, 4'd3, 16'h20C7, 8'h88},   // R3
      {1'b1, 4'd3, 16'h20C1, 8'h00},   // R3 untouched battery byte
      {1'b1, 4'd4, 16'h1000, 8'h00},   // R4
      {1'b1, 4'd4, 16'h2100, 8'h00},   // R4
      {1'b1, 4'd4, 16'hFFFF, 8'h00},   // R4
      {1'b1, 4'd4, 16'h1FFF, 8'h00},   // R4
      {1'b1, 4'd4, 16'h0000, 8'h11}    // R4 no alias from 0x1000 write
   };

   task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_errors++;
         $display("FAIL %s: got=%02h expected=%02h", req, got, exp);
      end
   endtask

   task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
      @(negedge clk);
      cpu_wr = 1'b0;
   endtask

   task automatic cpu_read(input logic [15:0] a, output logic [7:0] d);
      @(negedge clk);
      cpu_addr = a; cpu_rd = 1'b1;
      @(negedge clk);
      cpu_rd = 1'b0;
      d = cpu_rdata;
   endtask

   task automatic read_check(input string req, input logic [15:0] a, input logic [7:0] exp);
      logic [7:0] d;
      cpu_read(a, d);
      check(req, d, exp);
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
   endtask

   initial begin
      logic [7:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1; por_clr = 1'b0;
      @(negedge clk);
      check("R9 rdata after reset", cpu_rdata, 8'h00);

      // Vector table
      for (int i = 0; i < NV; i++) begin
         if (VEC[i][28] == 1'b0) begin
            cpu_write(VEC[i][23:8], VEC[i][7:0]);
         end else begin
            cpu_read(VEC[i][23:8], d);
            n_checks++;
            if (d !== VEC[i][7:0]) begin
               n_errors++;
               $display("FAIL R%0d vector %0d addr %04h: got=%02h expected=%02h",
                        VEC[i][27:24], i, VEC[i][23:8], d, VEC[i][7:0]);
            end
         end
      end

      // R1 hold: read then idle, data stays
      cpu_read(16'h0FFF, d);
      repeat (4) @(negedge clk);
      check("R1 hold while idle", cpu_rdata, 8'h22);

      // R6: divider zero blocks sample writes
      cpu_write(16'h0007, 8'h12);
      @(negedge clk);
      mux_div = 4'd0; adc_wr = 1'b1; adc_addr = 6'h07; adc_wdata = 8'hEE;
      @(negedge clk);
      adc_wr = 1'b0;
      read_check("R6 divider zero", 16'h0007, 8'h12);

      // R5: nonzero divider, edge indices
      @(negedge clk);
      mux_div = 4'd1; adc_wr = 1'b1; adc_addr = 6'h3F; adc_wdata = 8'h9C;
      @(negedge clk);
      adc_addr = 6'h07; adc_wdata = 8'h5E;
      @(negedge clk);
      adc_wr = 1'b0;
      read_check("R5 sample at 0x3F", 16'h003F, 8'h9C);
      read_check("R5 sample at 0x07", 16'h0007, 8'h5E);

      // R7: same-byte collision, sample wins
      @(negedge clk);
      mux_div = 4'd3;
      cpu_addr = 16'h0010; cpu_wdata = 8'hAA; cpu_wr = 1'b1;
      adc_wr = 1'b1; adc_addr = 6'h10; adc_wdata = 8'h55;
      @(negedge clk);
      cpu_wr = 1'b0; adc_wr = 1'b0;
      read_check("R7 same byte", 16'h0010, 8'h55);

      // R7: different bytes in window, CPU byte dropped
      cpu_write(16'h0020, 8'h11);
      @(negedge clk);
      cpu_addr = 16'h0020; cpu_wdata = 8'h22; cpu_wr = 1'b1;
      adc_wr = 1'b1; adc_addr = 6'h05; adc_wdata = 8'h66;
      @(negedge clk);
      cpu_wr = 1'b0; adc_wr = 1'b0;
      read_check("R7 CPU byte dropped", 16'h0020, 8'h11);
      read_check("R7 sample stored", 16'h0005, 8'h66);

      // R8: CPU above window completes alongside sample
      @(negedge clk);
      cpu_addr = 16'h0040; cpu_wdata = 8'h3C; cpu_wr = 1'b1;
      adc_wr = 1'b1; adc_addr = 6'h00; adc_wdata = 8'hC3;
      @(negedge clk);
      cpu_wr = 1'b0; adc_wr = 1'b0;
      read_check("R8 CPU at 0x40", 16'h0040, 8'h3C);
      read_check("R8 sample at 0x00", 16'h0000, 8'hC3);

      // R11: read-first on same-cycle read and write
      cpu_write(16'h0100, 8'h01);
      @(negedge clk);
      cpu_addr = 16'h0100; cpu_wdata = 8'h02; cpu_wr = 1'b1; cpu_rd = 1'b1;
      @(negedge clk);
      cpu_wr = 1'b0; cpu_rd = 1'b0;
      check("R11 old data", cpu_rdata, 8'h01);
      read_check("R11 new data", 16'h0100, 8'h02);

      // R9/R10: reset clears volatile, keeps battery
      cpu_write(16'h20C3, 8'hC3);
      cpu_write(16'h0123, 8'h5A);
      cpu_write(16'h2010, 8'hA5);
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R9 rdata after second reset", cpu_rdata, 8'h00);
      read_check("R9 shared cleared", 16'h0123, 8'h00);
      read_check("R9 config cleared", 16'h2010, 8'h00);
      read_check("R10 battery kept", 16'h20C3, 8'hC3);
      read_check("R10 battery kept 0x20C7", 16'h20C7, 8'h88);
      @(negedge clk);
      por_clr = 1'b1;
      @(negedge clk);
      por_clr = 1'b0;
      read_check("R10 battery cleared", 16'h20C3, 8'h00);
      read_check("R10 battery cleared 0x20C0", 16'h20C0, 8'h00);

      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      #1000000;
      if (!done) begin
         n_errors++;
         n_checks++;
         $display("FAIL watchdog (all requirements): got=running expected=finished");
         summary();
         $finish;
      end
   end
endmodule